// File: doc/BRIEF.md
# Register-Addressed Move Machine

This block is the control and datapath of a small stored-program processor. Every programmer-visible register has a 4-bit register address: the four general registers, the program counter, the accumulator, the memory address register and the memory buffer register. One move instruction copies any of these registers into any other. Memory is reached only through the address register. A program first loads an address into it, either as a 12-bit immediate or by a move. A load or save instruction then transfers a general register to or from that address.

Each instruction takes three cycles: fetch, latch into the instruction register, execute. A memory load adds a fourth cycle for write-back. The memory port expects synchronous-read memory with one cycle of latency, so a block RAM fits it directly. An add instruction accumulates a general register into the accumulator. A conditional jump branches when the accumulator is zero. Any malformed instruction halts the machine. The debug outputs show every register at all times.

Top module: `regmove_core`

## Requirements
- R1: While `rst` is high, all registers read zero on the debug outputs and `halted` is low. After reset, the first fetch is from address 0.
- R2: Instruction `0001 0000 dddd ssss` copies the register at address `ssss` into the register at address `dddd`. The register addresses are 0–3 for general registers R0–R3, 4 for PC, 5 for AC, 6 for MAR and 7 for MBR. PC and MAR take the low 12 bits of the value; reads of PC and MAR are zero-extended.
- R3: A move whose destination is AC must take a general register (address 0–3) as its source. A move whose source is AC must name a general register as its destination. Any other move that involves AC halts the machine and changes no register.
- R4: Opcode `0011` (bits 15:12) loads bits 11:0 into MAR.
- R5: Opcode `0101` reads memory at MAR and writes the value into the general register named by bits 1:0 and into MBR.
- R6: Opcode `0110` writes the general register named by bits 1:0 to memory at MAR and copies it into MBR. The memory write strobe is high only during such an instruction.
- R7: Opcode `OP_ADD` (default `0100`) adds the general register named by bits 1:0 into AC, wrapping modulo 2^16.
- R8: Opcode `OP_JZ` (default `0111`) sets PC to bits 11:0 when AC is zero. Otherwise it advances PC by one.
- R9: A move with PC as destination sets PC to the source value in place of the increment.
- R10: The machine halts on any of the following: a register address of 8–15 in a move, nonzero bits 11:8 in a move, a load, save or add operand nibble of 4–15, or any other opcode. This includes `0000`. Once halted, `halted` stays high, PC keeps the address of the offending instruction, no register changes and memory is never written.
- R11: Each completed instruction other than a jump or a move to PC advances PC by one. Reading PC as a move source gives the address of the moving instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory word address (PC in fetch, MAR otherwise) |
| mem_rd_en | output | 1 | Memory read request; data valid one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_rd_en` |
| dbg_gpr | output | 4*DATA_W | R0–R3, R0 in the low bits |
| dbg_pc | output | ADDR_W | Program counter |
| dbg_ac | output | DATA_W | Accumulator |
| dbg_mar | output | ADDR_W | Memory address register |
| dbg_mbr | output | DATA_W | Memory buffer register |
| halted | output | 1 | Machine has stopped on an illegal instruction |

## Verification
The bench runs short programs, each chosen to separate one behaviour from a plausible wrong one.

- **Register chain.** A chain of moves passes one loaded value through every register class. A wrong source or destination decode leaves some register with the wrong value.
- **Accumulation and store.** Adding 0xFFFF and 3 checks the modulo wrap, and a store confirms the sum reaches memory.
- **Branches.** A taken and a not-taken jump land on different halt addresses. Likewise, a move to PC halts at a different address than an ordinary increment would.
- **Illegal forms.** Each illegal form is placed after a legal instruction. This shows the halt fires at the right instruction and leaves PC and the registers frozen.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

  localparam int INSTR_W = 16;
  localparam int RADDR_W = 4;

  localparam logic [RADDR_W-1:0] RA_PC  = 4'd4;
  localparam logic [RADDR_W-1:0] RA_AC  = 4'd5;
  localparam logic [RADDR_W-1:0] RA_MAR = 4'd6;
  localparam logic [RADDR_W-1:0] RA_MBR = 4'd7;

  localparam logic [3:0] OPC_MOVE = 4'b0001;
  localparam logic [3:0] OPC_MARI = 4'b0011;
  localparam logic [3:0] OPC_LOAD = 4'b0101;
  localparam logic [3:0] OPC_SAVE = 4'b0110;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LATCH,
    ST_EXEC,
    ST_LOADWB,
    ST_HALT
  } state_t;

  typedef struct packed {
    logic               is_move;
    logic               is_mari;
    logic               is_load;
    logic               is_save;
    logic               is_add;
    logic               is_jz;
    logic               illegal;
    logic [RADDR_W-1:0] dst;
    logic [RADDR_W-1:0] src;
  } dec_t;

endpackage

// File: rtl/regmove_decode.sv
module regmove_decode
  import regmove_pkg::*;
#(
  parameter logic [3:0] OP_ADD = 4'b0100,
  parameter logic [3:0] OP_JZ  = 4'b0111
) (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic [3:0] opc;
  logic       gpr_operand;
  logic       ac_dst_bad;
  logic       ac_src_bad;

  assign opc         = instr[15:12];
  assign gpr_operand = (instr[3:2] == 2'b00);

  // AC only trades values with the general registers
  assign ac_dst_bad = (instr[7:4] == RA_AC) && (instr[3:2] != 2'b00);
  assign ac_src_bad = (instr[3:0] == RA_AC) && (instr[7:6] != 2'b00);

  always_comb begin
    dec     = '0;
    dec.dst = instr[7:4];
    dec.src = instr[3:0];
    if (opc == OPC_MOVE) begin
      dec.is_move = 1'b1;
      dec.illegal = (instr[11:8] != 4'b0000) || instr[7] || instr[3] ||
                    ac_dst_bad || ac_src_bad;
    end else if (opc == OPC_MARI) begin
      dec.is_mari = 1'b1;
    end else if (opc == OPC_LOAD) begin
      dec.is_load = 1'b1;
      dec.illegal = !gpr_operand;
    end else if (opc == OPC_SAVE) begin
      dec.is_save = 1'b1;
      dec.illegal = !gpr_operand;
    end else if (opc == OP_ADD) begin
      dec.is_add  = 1'b1;
      dec.illegal = !gpr_operand;
    end else if (opc == OP_JZ) begin
      dec.is_jz = 1'b1;
    end else begin
      dec.illegal = 1'b1;
    end
  end

endmodule

// File: rtl/regmove_regfile.sv
module regmove_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        q <= wr_data;
      end
    end
    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/regmove_srcmux.sv
module regmove_srcmux
  import regmove_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [RADDR_W-1:0]  sel,
  input  logic [4*DATA_W-1:0] gpr_flat,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [DATA_W-1:0]   ac,
  input  logic [ADDR_W-1:0]   mar,
  input  logic [DATA_W-1:0]   mbr,
  output logic [DATA_W-1:0]   val
);

  localparam int PAD_W = DATA_W - ADDR_W;

  always_comb begin
    case (sel)
      4'd0:    val = gpr_flat[0*DATA_W +: DATA_W];
      4'd1:    val = gpr_flat[1*DATA_W +: DATA_W];
      4'd2:    val = gpr_flat[2*DATA_W +: DATA_W];
      4'd3:    val = gpr_flat[3*DATA_W +: DATA_W];
      RA_PC:   val = {{PAD_W{1'b0}}, pc};
      RA_AC:   val = ac;
      RA_MAR:  val = {{PAD_W{1'b0}}, mar};
      RA_MBR:  val = mbr;
      default: val = '0;
    endcase
  end

endmodule

// File: rtl/regmove_core.sv
module regmove_core
  import regmove_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter int         ADDR_W = 12,
  parameter logic [3:0] OP_ADD = 4'b0100,
  parameter logic [3:0] OP_JZ  = 4'b0111
) (
  input  logic                clk,
  input  logic                rst,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd_en,
  output logic                mem_wr_en,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [4*DATA_W-1:0] dbg_gpr,
  output logic [ADDR_W-1:0]   dbg_pc,
  output logic [DATA_W-1:0]   dbg_ac,
  output logic [ADDR_W-1:0]   dbg_mar,
  output logic [DATA_W-1:0]   dbg_mbr,
  output logic                halted
);

  localparam int NUM_GPR = 4;
  localparam int GSEL_W  = $clog2(NUM_GPR);

  state_t               state;
  logic [INSTR_W-1:0]   ir;
  logic [ADDR_W-1:0]    pc;
  logic [ADDR_W-1:0]    mar;
  logic [DATA_W-1:0]    ac;
  logic [DATA_W-1:0]    mbr;
  dec_t                 dec;
  logic                 in_exec;
  logic                 exec_ok;
  logic [RADDR_W-1:0]   src_sel;
  logic [DATA_W-1:0]    src_val;
  logic                 gpr_we;
  logic [GSEL_W-1:0]    gpr_wsel;
  logic [DATA_W-1:0]    gpr_wdata;
  logic [ADDR_W-1:0]    pc_next_seq;

  regmove_decode #(
    .OP_ADD(OP_ADD),
    .OP_JZ (OP_JZ)
  ) u_decode (
    .instr(ir),
    .dec  (dec)
  );

  assign in_exec = (state == ST_EXEC);
  assign exec_ok = in_exec && !dec.illegal;

  // move reads its source field; load/save/add read the general register in bits 1:0
  assign src_sel = dec.is_move ? dec.src : {2'b00, ir[1:0]};

  regmove_srcmux #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_srcmux (
    .sel     (src_sel),
    .gpr_flat(dbg_gpr),
    .pc      (pc),
    .ac      (ac),
    .mar     (mar),
    .mbr     (mbr),
    .val     (src_val)
  );

  assign gpr_we    = (state == ST_LOADWB) ||
                     (exec_ok && dec.is_move && (dec.dst[3:2] == 2'b00));
  assign gpr_wsel  = (state == ST_LOADWB) ? ir[1:0] : dec.dst[1:0];
  assign gpr_wdata = (state == ST_LOADWB) ? mem_rdata : src_val;

  regmove_regfile #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_GPR)
  ) u_regfile (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (gpr_we),
    .wr_sel   (gpr_wsel),
    .wr_data  (gpr_wdata),
    .regs_flat(dbg_gpr)
  );

  assign pc_next_seq = pc + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      ir    <= '0;
      pc    <= '0;
      mar   <= '0;
      ac    <= '0;
      mbr   <= '0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: begin
          ir    <= mem_rdata[INSTR_W-1:0];
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (dec.illegal) begin
            state <= ST_HALT;
          end else begin
            state <= dec.is_load ? ST_LOADWB : ST_FETCH;
            pc    <= pc_next_seq;
            if (dec.is_move) begin
              case (dec.dst)
                RA_PC:   pc  <= src_val[ADDR_W-1:0];
                RA_AC:   ac  <= src_val;
                RA_MAR:  mar <= src_val[ADDR_W-1:0];
                RA_MBR:  mbr <= src_val;
                default: ;
              endcase
            end
            if (dec.is_mari) mar <= ir[ADDR_W-1:0];
            if (dec.is_save) mbr <= src_val;
            if (dec.is_add)  ac  <= ac + src_val;
            if (dec.is_jz && (ac == '0)) pc <= ir[ADDR_W-1:0];
          end
        end
        ST_LOADWB: begin
          mbr   <= mem_rdata;
          state <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_addr  = (state == ST_FETCH) ? pc : mar;
  assign mem_rd_en = (state == ST_FETCH) || (exec_ok && dec.is_load);
  assign mem_wr_en = exec_ok && dec.is_save;
  assign mem_wdata = src_val;

  assign dbg_pc  = pc;
  assign dbg_ac  = ac;
  assign dbg_mar = mar;
  assign dbg_mbr = mbr;
  assign halted  = (state == ST_HALT);

endmodule

// File: rtl/regmove_core_chk.sv
module regmove_core_chk
  import regmove_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter int         ADDR_W = 12,
  parameter logic [3:0] OP_JZ  = 4'b0111
) (
  input logic                clk,
  input logic                rst,
  input state_t              state,
  input logic [INSTR_W-1:0]  ir,
  input logic                mem_wr_en,
  input logic [4*DATA_W-1:0] dbg_gpr,
  input logic [ADDR_W-1:0]   dbg_pc,
  input logic [DATA_W-1:0]   dbg_ac,
  input logic [ADDR_W-1:0]   dbg_mar,
  input logic [DATA_W-1:0]   dbg_mbr,
  input logic                halted
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (dbg_pc == '0 && dbg_ac == '0 && dbg_mar == '0 &&
             dbg_mbr == '0 && dbg_gpr == '0 && !halted));

  p_mar_imm_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && ir[15:12] == OPC_MARI) |=>
      dbg_mar == $past(ir[ADDR_W-1:0]));

  p_write_only_save_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (state == ST_EXEC && ir[15:12] == OPC_SAVE));

  p_jz_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && ir[15:12] == OP_JZ && dbg_ac == '0) |=>
      dbg_pc == $past(ir[ADDR_W-1:0]));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(dbg_pc) && $stable(dbg_ac) && $stable(dbg_gpr) &&
                $stable(dbg_mar) && $stable(dbg_mbr) && !mem_wr_en));

  p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && ir[15:12] == OPC_MARI) |=>
      dbg_pc == $past(dbg_pc) + ADDR_W'(1));

endmodule

bind regmove_core regmove_core_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .OP_JZ (OP_JZ)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .state    (state),
  .ir       (ir),
  .mem_wr_en(mem_wr_en),
  .dbg_gpr  (dbg_gpr),
  .dbg_pc   (dbg_pc),
  .dbg_ac   (dbg_ac),
  .dbg_mar  (dbg_mar),
  .dbg_mbr  (dbg_mbr),
  .halted   (halted)
);

// File: tb/regmove_core_tb_top.sv
module regmove_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 12;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd_en;
  logic              mem_wr_en;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic [4*DATA_W-1:0] dbg_gpr;
  logic [ADDR_W-1:0] dbg_pc;
  logic [DATA_W-1:0] dbg_ac;
  logic [ADDR_W-1:0] dbg_mar;
  logic [DATA_W-1:0] dbg_mbr;
  logic              halted;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int halt_writes = 0;

  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  logic              tb_we = 1'b0;
  logic [ADDR_W-1:0] tb_addr = '0;
  logic [DATA_W-1:0] tb_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmove_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .dbg_gpr  (dbg_gpr),
    .dbg_pc   (dbg_pc),
    .dbg_ac   (dbg_ac),
    .dbg_mar  (dbg_mar),
    .dbg_mbr  (dbg_mbr),
    .halted   (halted)
  );

  // synchronous-read memory model with a bench load port
  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (halted && mem_wr_en) halt_writes <= halt_writes + 1;
  end

  function automatic logic [DATA_W-1:0] gpr(input int n);
    return dbg_gpr[n*DATA_W +: DATA_W];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    tb_addr = a;
    tb_data = d;
    tb_we   = 1'b1;
    @(posedge clk);
    #1 tb_we = 1'b0;
  endtask

  task automatic begin_prog();
    rst = 1'b1;
    @(posedge clk);
    #1;
    for (int a = 0; a < 256; a++) poke(ADDR_W'(a), '0);
    halt_writes = 0;
  endtask

  task automatic run_prog();
    int n;
    @(posedge clk);
    #1 rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    begin_prog();
    poke(12'h000, 16'h3055);
    @(negedge clk);
    chk("R1", "pc", dbg_pc, 0);
    chk("R1", "ac", dbg_ac, 0);
    chk("R1", "gpr", dbg_gpr, 0);
    chk("R1", "mar_mbr", {dbg_mar, dbg_mbr}, 0);
    chk("R1", "halted", halted, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "first fetch addr", mem_addr, 0);
    chk("R1", "first fetch rd", mem_rd_en, 1);
  endtask

  task automatic t_moves();
    begin_prog();
    poke(12'h080, 16'h1234);
    poke(0, 16'h3080);
    poke(1, 16'h5001);
    poke(2, 16'h1021);
    poke(3, 16'h1052);
    poke(4, 16'h1005);
    poke(5, 16'h1070);
    poke(6, 16'h1034);
    run_prog();
    chk("R5", "load R1", gpr(1), 16'h1234);
    chk("R2", "R2<-R1", gpr(2), 16'h1234);
    chk("R3", "AC<-R2", dbg_ac, 16'h1234);
    chk("R3", "R0<-AC", gpr(0), 16'h1234);
    chk("R2", "MBR<-R0", dbg_mbr, 16'h1234);
    chk("R4", "mar imm", dbg_mar, 12'h080);
    chk("R11", "R3<-PC", gpr(3), 6);
    chk("R11", "pc at halt", dbg_pc, 7);
    chk("R10", "halt on 0000", halted, 1);
  endtask

  task automatic t_save_add();
    begin_prog();
    poke(12'h090, 16'hFFFF);
    poke(12'h091, 16'h0003);
    poke(0, 16'h3090);
    poke(1, 16'h5000);
    poke(2, 16'h3091);
    poke(3, 16'h5001);
    poke(4, 16'h4000);
    poke(5, 16'h4001);
    poke(6, 16'h1025);
    poke(7, 16'h30A0);
    poke(8, 16'h6002);
    run_prog();
    chk("R7", "ac wrap", dbg_ac, 16'h0002);
    chk("R3", "R2<-AC", gpr(2), 16'h0002);
    chk("R6", "mem saved", mem[12'h0A0], 16'h0002);
    chk("R6", "mbr copy", dbg_mbr, 16'h0002);
    chk("R11", "pc", dbg_pc, 9);
  endtask

  task automatic t_jump();
    begin_prog();
    poke(12'h090, 16'h0007);
    poke(0, 16'h7005);
    poke(5, 16'h3090);
    poke(6, 16'h5000);
    poke(7, 16'h4000);
    poke(8, 16'h7010);
    run_prog();
    chk("R8", "ac", dbg_ac, 16'h0007);
    chk("R8", "taken then not taken", dbg_pc, 9);
  endtask

  task automatic t_move_pc();
    begin_prog();
    poke(12'h020, 16'h0040);
    poke(0, 16'h3020);
    poke(1, 16'h5003);
    poke(2, 16'h1043);
    run_prog();
    chk("R9", "pc from R3", dbg_pc, 12'h040);
  endtask

  task automatic t_ac_rule();
    begin_prog();
    poke(0, 16'h3011);
    poke(1, 16'h1054);
    run_prog();
    chk("R3", "halted", halted, 1);
    chk("R3", "pc", dbg_pc, 1);
    chk("R3", "ac unchanged", dbg_ac, 0);
    begin_prog();
    poke(0, 16'h3011);
    poke(1, 16'h1065);
    run_prog();
    chk("R3", "mar<-ac halted", halted, 1);
    chk("R3", "mar unchanged", dbg_mar, 12'h011);
  endtask

  task automatic t_bad_addr();
    logic [ADDR_W-1:0] pc_snap;
    begin_prog();
    poke(12'h055, 16'hABCD);
    poke(0, 16'h3055);
    poke(1, 16'h5000);
    poke(2, 16'h1008);
    poke(3, 16'h6000);
    run_prog();
    chk("R10", "halted", halted, 1);
    chk("R10", "pc", dbg_pc, 2);
    chk("R10", "R0 kept", gpr(0), 16'hABCD);
    pc_snap = dbg_pc;
    repeat (20) @(negedge clk);
    chk("R10", "pc frozen", dbg_pc, pc_snap);
    chk("R10", "still halted", halted, 1);
    chk("R10", "no writes", halt_writes, 0);
    chk("R10", "save not done", mem[12'h055], 16'hABCD);
  endtask

  task automatic t_unknown_op();
    begin_prog();
    poke(0, 16'h3033);
    poke(1, 16'hF000);
    run_prog();
    chk("R10", "unknown op halt", halted, 1);
    chk("R10", "unknown op pc", dbg_pc, 1);
    chk("R4", "mar", dbg_mar, 12'h033);
    begin_prog();
    poke(0, 16'h5004);
    run_prog();
    chk("R10", "load nibble 4 halt", halted, 1);
    chk("R10", "load nibble 4 pc", dbg_pc, 0);
    chk("R10", "mbr kept", dbg_mbr, 0);
  endtask

  initial begin
    t_reset();
    t_moves();
    t_save_add();
    t_jump();
    t_move_pc();
    t_ac_rule();
    t_bad_addr();
    t_unknown_op();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule